// File: doc/BRIEF.md
# USB IN Flush and Wakeup Controller

This block decides when data waiting in a device's host-bound transmit buffer is handed to the host on a bulk-IN request. A full packet goes out at once. A partial packet waits until a latency timer expires, and the timer's limit is programmable in whole milliseconds. Time comes from a 1 ms tick input, so the block does not need to know the system clock frequency.

A single active-low strobe pin has two meanings. During normal operation a falling edge on the pin forces the buffered data out on the next request, whatever its size. While the bus is suspended, and remote wakeup is enabled, the same edge raises a resume request. The block also drives an active-low power-enable output that tracks suspend. A pull-down enable for the parallel interface lines can be turned on while power is off.

Top module: `usb_in_flush_ctrl`

## Requirements
- R1: When `in_req_i` is high and `fifo_count_i` >= `max_pkt_i`, `send_o` pulses for one cycle, one clock after the request, with `zlp_o` low unless the count is 0.
- R2: When the latency timer has expired and the count is between 1 and `max_pkt_i`-1, the next request gets `send_o`=1 and `zlp_o`=0.
- R3: With a timeout of T, a partial count gets no send until T ticks of `tick_1ms_i` have arrived. An empty buffer never starts the timer.
- R4: The timer restarts whenever `fifo_count_i` rises and whenever a packet is sent.
- R5: The timeout resets to 16 ticks. A write through `tmo_we_i` sets it to `tmo_wdata_i`, and a write of 0 is stored as 1.
- R6: A falling edge on `siwu_ni` while `suspend_i`=0 sets a pending flag. The next request is then answered with `send_o`=1, and with `zlp_o`=1 if the count is 0. That answer clears the flag.
- R7: A falling edge on `siwu_ni` while `suspend_i`=1 and `rwu_en_i`=1 gives a one-cycle `resume_o` pulse, three clock edges after the pin is first sampled low.
- R8: A falling edge while suspended with `rwu_en_i`=0 has no effect: no resume and no pending flush.
- R9: `pwr_en_no` equals `suspend_i` delayed by one clock, so it is high while suspended. It resets low.
- R10: `pd_en_o` is high only while `pd_mode_i`=1 and `pwr_en_no`=1.
- R11: `send_o` is never high unless `in_req_i` was high on the previous clock.
- R12: A pin held low acts once. Only the falling edge counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_1ms_i | input | 1 | One-cycle pulse every millisecond |
| fifo_count_i | input | CNT_W | Transmit buffer occupancy in bytes |
| max_pkt_i | input | CNT_W | Full packet size |
| in_req_i | input | 1 | Bulk-IN request strobe |
| suspend_i | input | 1 | Bus suspended |
| rwu_en_i | input | 1 | Remote wakeup enabled |
| siwu_ni | input | 1 | Send-immediate / wakeup pin, active low |
| pd_mode_i | input | 1 | Enable pull-downs while power is off |
| tmo_we_i | input | 1 | Timeout register write strobe |
| tmo_wdata_i | input | TMO_W | Timeout value in ms |
| send_o | output | 1 | Send-packet command pulse |
| zlp_o | output | 1 | The commanded packet is zero length |
| resume_o | output | 1 | Resume request pulse |
| pwr_en_no | output | 1 | Power enable, active low |
| pd_en_o | output | 1 | Pull-down enable for the interface lines |

## Verification
`send_o` and `zlp_o` are registered, so they are due one clock after the edge that samples `in_req_i`. `pwr_en_no` also lags `suspend_i` by one clock. The bench changes inputs on falling edges and reads each result at the falling edge after that register loads. `resume_o` comes three edges after the pin is first sampled low: two synchroniser stages, then the output register. The bench checks that it is still low after the second edge and high after the third, and it counts pulses over a long window to prove a held-low pin acts only once. For timer cases the bench sends a known number of ticks and then one request, so the outcome does not depend on exact tick cycles.

// File: rtl/usb_flush_pkg.sv
package usb_flush_pkg;
  localparam int unsigned TMO_W   = 8;
  localparam int unsigned TMO_RST = 16;

  typedef enum logic [1:0] {
    STB_NONE   = 2'd0,
    STB_RESUME = 2'd1,
    STB_IMM    = 2'd2
  } stb_act_e;
endpackage

// File: rtl/siwu_sync.sv
module siwu_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= 1'b1;
        else         sync_q[i] <= pin_ni;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= 1'b1;
        else         sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b1;
    else         last_q <= sync_q[STAGES-1];

  assign fall_o = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/latency_timer.sv
module latency_timer
  import usb_flush_pkg::*;
#(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic             restart_i,
  input  logic             we_i,
  input  logic [TMO_W-1:0] wdata_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] tmo_q;
  logic [TMO_W-1:0] ms_q;
  logic             exp_q;
  logic             armed;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   tmo_q <= TMO_W'(TMO_RST);
    else if (we_i) tmo_q <= (wdata_i == '0) ? TMO_W'(1) : wdata_i;

  // counts only for a partial, non-empty buffer
  assign armed = (count_i != '0) && (count_i < max_i) && !exp_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ms_q  <= '0;
      exp_q <= 1'b0;
    end else if (restart_i) begin
      ms_q  <= '0;
      exp_q <= 1'b0;
    end else if (tick_i && armed) begin
      if (ms_q + TMO_W'(1) >= tmo_q) begin
        exp_q <= 1'b1;
        ms_q  <= '0;
      end else begin
        ms_q  <= ms_q + TMO_W'(1);
      end
    end

  assign expired_o = exp_q;
endmodule

// File: rtl/flush_decider.sv
module flush_decider #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_req_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic             expired_i,
  input  logic             imm_set_i,
  output logic             send_now_o,
  output logic             send_o,
  output logic             zlp_o
);
  logic imm_q;
  logic full;
  logic partial_ok;

  assign full       = count_i >= max_i;
  assign partial_ok = (count_i != '0) && expired_i;
  assign send_now_o = in_req_i && (full || partial_ok || imm_q || imm_set_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         imm_q <= 1'b0;
    else if (send_now_o) imm_q <= 1'b0;
    else if (imm_set_i)  imm_q <= 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      send_o <= 1'b0;
      zlp_o  <= 1'b0;
    end else begin
      send_o <= send_now_o;
      zlp_o  <= send_now_o && (count_i == '0);
    end
endmodule

// File: rtl/usb_in_flush_ctrl.sv
module usb_in_flush_ctrl
  import usb_flush_pkg::*;
#(
  parameter int unsigned CNT_W       = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_1ms_i,
  input  logic [CNT_W-1:0] fifo_count_i,
  input  logic [CNT_W-1:0] max_pkt_i,
  input  logic             in_req_i,
  input  logic             suspend_i,
  input  logic             rwu_en_i,
  input  logic             siwu_ni,
  input  logic             pd_mode_i,
  input  logic             tmo_we_i,
  input  logic [TMO_W-1:0] tmo_wdata_i,
  output logic             send_o,
  output logic             zlp_o,
  output logic             resume_o,
  output logic             pwr_en_no,
  output logic             pd_en_o
);
  logic [CNT_W-1:0] prev_cnt_q;
  logic             grow;
  logic             fall;
  logic             expired;
  logic             send_now;
  stb_act_e         act;
  logic             resume_q;
  logic             pwr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_cnt_q <= '0;
    else         prev_cnt_q <= fifo_count_i;

  assign grow = fifo_count_i > prev_cnt_q;

  siwu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_ni (siwu_ni),
    .fall_o (fall)
  );

  always_comb begin
    act = STB_NONE;
    if (fall) begin
      if (!suspend_i)    act = STB_IMM;
      else if (rwu_en_i) act = STB_RESUME;
    end
  end

  latency_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_1ms_i),
    .count_i   (fifo_count_i),
    .max_i     (max_pkt_i),
    .restart_i (grow | send_now),
    .we_i      (tmo_we_i),
    .wdata_i   (tmo_wdata_i),
    .expired_o (expired)
  );

  flush_decider #(.CNT_W(CNT_W)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_req_i   (in_req_i),
    .count_i    (fifo_count_i),
    .max_i      (max_pkt_i),
    .expired_i  (expired),
    .imm_set_i  (act == STB_IMM),
    .send_now_o (send_now),
    .send_o     (send_o),
    .zlp_o      (zlp_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      resume_q <= 1'b0;
      pwr_q    <= 1'b0;
    end else begin
      resume_q <= (act == STB_RESUME);
      pwr_q    <= suspend_i;
    end

  assign resume_o  = resume_q;
  assign pwr_en_no = pwr_q;
  assign pd_en_o   = pd_mode_i & pwr_q;
endmodule

// File: rtl/usb_in_flush_ctrl_chk.sv
module usb_in_flush_ctrl_chk #(
  parameter int unsigned CNT_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_req_i,
  input logic [CNT_W-1:0] fifo_count_i,
  input logic [CNT_W-1:0] max_pkt_i,
  input logic             suspend_i,
  input logic             rwu_en_i,
  input logic             send_o,
  input logic             zlp_o,
  input logic             resume_o,
  input logic             pwr_en_no,
  input logic             pd_en_o
);
  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;

  a_r1_full_sends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_req_i && (fifo_count_i >= max_pkt_i) |=> send_o);
  a_r6_zlp_with_send: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zlp_o |-> send_o);
  a_r7_resume_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o);
  a_r7_resume_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o && past_ok_q |-> $past(suspend_i && rwu_en_i));
  a_r9_pwr_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> (pwr_en_no == $past(suspend_i)));
  a_r10_pd_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_en_o && past_ok_q |-> $past(suspend_i));
  a_r11_send_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_o && past_ok_q |-> $past(in_req_i));
endmodule

bind usb_in_flush_ctrl usb_in_flush_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_req_i     (in_req_i),
  .fifo_count_i (fifo_count_i),
  .max_pkt_i    (max_pkt_i),
  .suspend_i    (suspend_i),
  .rwu_en_i     (rwu_en_i),
  .send_o       (send_o),
  .zlp_o        (zlp_o),
  .resume_o     (resume_o),
  .pwr_en_no    (pwr_en_no),
  .pd_en_o      (pd_en_o)
);

// File: tb/usb_in_flush_ctrl_test.sv
module usb_in_flush_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 11;
  localparam int NV         = 9;
  // {count[7:0], ticks[7:0], pad, imm(bit2), exp_send(bit1), exp_zlp(bit0)}
  localparam logic [31:0] VEC [NV] = '{
    32'h050F_0000, 32'h0510_0002, 32'h4000_0002, 32'h6400_0002,
    32'h0014_0000, 32'h0000_0007, 32'h0300_0006, 32'h3F10_0002,
    32'h3F0A_0000
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, req = 0, susp = 0, rwu = 0, siwu = 1, pdm = 0, we = 0;
  logic [CNT_W-1:0] cnt = '0, maxp = 11'd64;
  logic [7:0] wdata = '0;
  logic send, zlp, resume, pwr_n, pd_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_in_flush_ctrl #(.CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_1ms_i(tick), .fifo_count_i(cnt),
    .max_pkt_i(maxp), .in_req_i(req), .suspend_i(susp), .rwu_en_i(rwu),
    .siwu_ni(siwu), .pd_mode_i(pdm), .tmo_we_i(we), .tmo_wdata_i(wdata),
    .send_o(send), .zlp_o(zlp), .resume_o(resume), .pwr_en_no(pwr_n),
    .pd_en_o(pd_en)
  );

  task automatic chk(input string r, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", r, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; cyc(1); tick = 0; cyc(1);
    end
  endtask

  task automatic request(output logic s, output logic z);
    req = 1; cyc(1); req = 0;
    s = send; z = zlp;
  endtask

  task automatic strobe();
    siwu = 0; cyc(2); siwu = 1; cyc(4);
  endtask

  task automatic set_count(input int c);
    cnt = '0; cyc(2); cnt = CNT_W'(c); cyc(2);
  endtask

  task automatic write_tmo(input int v);
    wdata = 8'(v); we = 1; cyc(1); we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic s, z;
    int pulses;
    cyc(3); rst_n = 1; cyc(1);
    // reset state
    chk("R9 reset pwr_en_no", pwr_n, 1'b0);
    chk("R10 reset pd_en_o", pd_en, 1'b0);
    chk("R7 reset resume_o", resume, 1'b0);
    chk("R11 reset send_o", send, 1'b0);

    // vector table: default timeout 16 (R5), max packet 64
    for (int v = 0; v < NV; v++) begin
      set_count(int'(VEC[v][31:24]));
      if (VEC[v][2]) strobe();
      ticks(int'(VEC[v][23:16]));
      request(s, z);
      chk($sformatf("R1/R2/R3/R6 vec%0d send", v), s, VEC[v][1]);
      chk($sformatf("R6 vec%0d zlp", v), z, VEC[v][0]);
      cyc(1);
      chk($sformatf("R11 vec%0d single pulse", v), send, 1'b0);
    end

    // R4: restart on new data
    set_count(5); ticks(10); cnt = 11'd6; cyc(2); ticks(10);
    request(s, z); chk("R4 growth restarts timer", s, 1'b0);
    ticks(6); request(s, z); chk("R4 expiry after restart", s, 1'b1);
    // R4: restart on send (count unchanged)
    cyc(1); request(s, z); chk("R4 send restarts timer", s, 1'b0);

    // R5: write of 0 clamps to 1
    write_tmo(0);
    set_count(5); ticks(1); request(s, z); chk("R5 zero clamped to 1", s, 1'b1);
    write_tmo(3);
    set_count(5); ticks(2); request(s, z); chk("R5 timeout 3 not yet", s, 1'b0);
    ticks(1); request(s, z); chk("R5 timeout 3 expired", s, 1'b1);

    // R9/R10 suspend and pull-down
    set_count(0);
    susp = 1; pdm = 0; cyc(1);
    chk("R9 pwr_en_no high in suspend", pwr_n, 1'b1);
    chk("R10 pd off when mode clear", pd_en, 1'b0);
    pdm = 1; #1;
    chk("R10 pd on when mode set", pd_en, 1'b1);

    // R7: resume latency: pin low at this negedge
    rwu = 1; siwu = 0;
    cyc(2); chk("R7 resume not before third edge", resume, 1'b0);
    cyc(1); chk("R7 resume on third edge", resume, 1'b1);
    // R12: pin held low, count pulses
    pulses = 0;
    for (int i = 0; i < 20; i++) begin cyc(1); if (resume) pulses++; end
    siwu = 1; cyc(4);
    chk("R12 held pin one resume", pulses == 0, 1'b1);

    // R8: suspended, wakeup disabled
    rwu = 0; siwu = 0; pulses = 0;
    for (int i = 0; i < 8; i++) begin cyc(1); if (resume) pulses++; end
    siwu = 1; cyc(3);
    chk("R8 no resume without enable", pulses == 0, 1'b1);
    susp = 0; cyc(1);
    chk("R9 pwr_en_no low after suspend", pwr_n, 1'b0);
    chk("R10 pd off after suspend", pd_en, 1'b0);
    request(s, z); chk("R8 no pending flush after ignored edge", s, 1'b0);

    // R12: held low while active: one flush only
    siwu = 0; cyc(6);
    request(s, z); chk("R12 first request after edge", s, 1'b1);
    cyc(1);
    request(s, z); chk("R12 no second flush while held", s, 1'b0);
    siwu = 1; cyc(4);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule